// File: doc/BRIEF.md
# Throttled Spill Target Picker

This block decides where a victim line goes when a private L2 in a four-core ring evicts a line that has no other copy on the chip. For each spill request it first decides whether to cooperate at all. That decision is a random trial against a programmable probability. If the trial fails, the victim is not spilled and goes down the hierarchy as usual. If the trial succeeds, the block picks a host core by a weighted random draw. The draw favours the two cores next to the source on the ring and never picks the source itself. The victim is then pushed straight to that host. The data move happens elsewhere; this block only supplies the decision.

A single free-running linear-feedback shift register supplies every random bit. Its state can be loaded from a port, so a run can be repeated exactly. A low probability setting makes the private caches behave almost as if they were isolated. A high setting lets them pool capacity like one shared L2. Every request gets exactly one response, one cycle later.

Top module: `spill_picker`

## Requirements
- R1: While reset is asserted and in every cycle without a response, resp_valid, resp_spill and resp_target are all 0.
- R2: resp_valid is 1 in the cycle after a cycle with req_valid = 1 and is 0 in the cycle after a cycle with req_valid = 0. Back-to-back requests each get their own response.
- R3: The random state is a 16-bit right-shifting Galois register with feedback mask 0xB400: next = (s >> 1) XOR (s[0] ? 0xB400 : 0). It resets to 0xACE1 and steps on every clock, whether or not a request is present.
- R4: When seed_load = 1, the state takes seed_value at that clock edge, and a value of 0 is replaced by 0x0001. A request in that same cycle still uses the state held before the load.
- R5: A request cooperates (resp_spill = 1) when state bits [7:0], read as an unsigned number, are less than coop_prob.
- R6: With coop_prob = 0 no request ever spills.
- R7: With coop_prob = 255 every request spills.
- R8: The draw code is state bits [10:8] (values 0 to 7). Codes 0 to 2 select (src+1) mod 4, codes 3 to 5 select (src+3) mod 4, and codes 6 and 7 select (src+2) mod 4. The two neighbours therefore have weight 3 each and the opposite core weight 2.
- R9: When resp_spill = 1, resp_target never equals the req_src of the request it answers.
- R10: A response with resp_spill = 0 carries resp_target = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted synchronously to clk |
| seed_load | input | 1 | Load seed_value into the random state at this edge |
| seed_value | input | 16 | Seed; 0 is replaced by 1 |
| coop_prob | input | 8 | Cooperation threshold, 0 = never spill, 255 = always spill |
| req_valid | input | 1 | Spill request present |
| req_src | input | 2 | Ring index of the core that evicts the victim |
| resp_valid | output | 1 | Response present, one cycle after the request |
| resp_spill | output | 1 | 1 = push the victim to resp_target, 0 = do not spill |
| resp_target | output | 2 | Host core for the victim, 0 when not spilling |

## Verification
The hardest cases to reach from the ports are the edges of the decision ranges. These include a random byte exactly equal to the threshold, each of the eight draw codes for each source core, and a request that lands in the same cycle as a seed load. The bench loads known seeds and tracks the random state arithmetically from the polynomial. It then sweeps every source core against a set of thresholds, including 0, 1, 254 and 255, over long back-to-back runs so that all draw codes come up. It also issues a request in the same cycle as a zero-seed load, to show that the old state is used and that the substitute seed takes effect afterwards.

// File: rtl/spill_pkg.sv
package spill_pkg;

  // Default geometry of the ring and the random source.
  localparam int unsigned CORE_COUNT  = 4;
  localparam int unsigned RAND_WIDTH  = 16;
  localparam logic [15:0] RAND_TAPS   = 16'hB400;
  localparam logic [15:0] RAND_RESET  = 16'hACE1;
  localparam int unsigned THRESH_W    = 8;
  localparam int unsigned DRAW_W      = 3;
  localparam int unsigned NEAR_WEIGHT = 3;
  localparam int unsigned FAR_WEIGHT  = 2;

  // Direction of the chosen host relative to the source on the ring.
  typedef enum logic [1:0] {
    DIR_CLOCKWISE = 2'd0,
    DIR_COUNTER   = 2'd1,
    DIR_OPPOSITE  = 2'd2
  } ring_dir_e;

endpackage

// File: rtl/spill_lfsr.sv
module spill_lfsr #(
  parameter int unsigned             WIDTH     = spill_pkg::RAND_WIDTH,
  parameter logic [WIDTH-1:0]        TAPS      = spill_pkg::RAND_TAPS,
  parameter logic [WIDTH-1:0]        RESET_VAL = spill_pkg::RAND_RESET,
  parameter int unsigned             OUT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  output logic [OUT_W-1:0] rnd
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] seed_fixed;

  // An all-zero state would lock the register, so substitute 1.
  always_comb begin
    seed_fixed = load_val;
    if (load_val == '0) begin
      seed_fixed = {{(WIDTH-1){1'b0}}, 1'b1};
    end
  end

  always_comb begin
    if (load_en) begin
      state_d = seed_fixed;
    end else begin
      state_d = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_VAL;
    end else begin
      state_q <= state_d;
    end
  end

  assign rnd = state_q[OUT_W-1:0];

endmodule

// File: rtl/spill_coop_gate.sv
module spill_coop_gate #(
  parameter int unsigned PROB_W = spill_pkg::THRESH_W
) (
  input  logic [PROB_W-1:0] rnd_byte,
  input  logic [PROB_W-1:0] prob,
  output logic              coop
);

  localparam logic [PROB_W-1:0] PROB_MAX = '1;

  // Strict compare gives 0 -> never. The top code is forced so that the
  // maximum setting means always rather than 255 out of 256.
  always_comb begin
    coop = (rnd_byte < prob) || (prob == PROB_MAX);
  end

endmodule

// File: rtl/spill_target_sel.sv
module spill_target_sel
  import spill_pkg::*;
#(
  parameter int unsigned NUM_CORES = CORE_COUNT,
  parameter int unsigned SEL_W     = DRAW_W,
  parameter int unsigned W_NEAR    = NEAR_WEIGHT,
  parameter int unsigned W_FAR     = FAR_WEIGHT,
  localparam int unsigned ID_W     = $clog2(NUM_CORES)
) (
  input  logic [ID_W-1:0]  src,
  input  logic [SEL_W-1:0] code,
  output logic [ID_W-1:0]  target
);

  localparam int unsigned CW_END  = W_NEAR;
  localparam int unsigned CCW_END = 2 * W_NEAR;
  localparam int unsigned ALL_END = 2 * W_NEAR + W_FAR;
  localparam logic [ID_W-1:0] STEP_ONE  = ID_W'(1);
  localparam logic [ID_W-1:0] STEP_HALF = ID_W'(NUM_CORES / 2);

  ring_dir_e dir;

  // Ring arithmetic wraps naturally because NUM_CORES is a power of two.
  initial begin
    if ((1 << ID_W) != NUM_CORES) $error("NUM_CORES must be a power of two");
    if (ALL_END > (1 << SEL_W)) $error("weights exceed draw range");
  end

  always_comb begin
    if (int'(code) < CW_END) begin
      dir = DIR_CLOCKWISE;
    end else if (int'(code) < CCW_END) begin
      dir = DIR_COUNTER;
    end else begin
      dir = DIR_OPPOSITE;
    end
  end

  always_comb begin
    unique case (dir)
      DIR_CLOCKWISE: target = src + STEP_ONE;
      DIR_COUNTER:   target = src - STEP_ONE;
      default:       target = src + STEP_HALF;
    endcase
  end

endmodule

// File: rtl/spill_picker.sv
module spill_picker
  import spill_pkg::*;
#(
  parameter int unsigned NUM_CORES = CORE_COUNT,
  parameter int unsigned LFSR_W    = RAND_WIDTH,
  parameter int unsigned PROB_W    = THRESH_W,
  parameter int unsigned SEL_W     = DRAW_W,
  localparam int unsigned ID_W     = $clog2(NUM_CORES),
  localparam int unsigned USED_W   = PROB_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_value,
  input  logic [PROB_W-1:0] coop_prob,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_src,
  output logic              resp_valid,
  output logic              resp_spill,
  output logic [ID_W-1:0]   resp_target
);

  logic [USED_W-1:0] rnd;
  logic              coop;
  logic [ID_W-1:0]   pick;

  logic              valid_d, valid_q;
  logic              spill_d, spill_q;
  logic [ID_W-1:0]   target_d, target_q;
  logic              out_en;

  spill_lfsr #(
    .WIDTH    (LFSR_W),
    .TAPS     (LFSR_W'(RAND_TAPS)),
    .RESET_VAL(LFSR_W'(RAND_RESET)),
    .OUT_W    (USED_W)
  ) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (seed_load),
    .load_val(seed_value),
    .rnd     (rnd)
  );

  spill_coop_gate #(
    .PROB_W(PROB_W)
  ) u_gate (
    .rnd_byte(rnd[PROB_W-1:0]),
    .prob    (coop_prob),
    .coop    (coop)
  );

  spill_target_sel #(
    .NUM_CORES(NUM_CORES),
    .SEL_W    (SEL_W)
  ) u_sel (
    .src   (req_src),
    .code  (rnd[PROB_W +: SEL_W]),
    .target(pick)
  );

  // Responses update whenever a request arrives or one must be retired.
  assign out_en = req_valid | valid_q;

  always_comb begin
    valid_d  = req_valid;
    spill_d  = req_valid & coop;
    target_d = spill_d ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      spill_q  <= 1'b0;
      target_q <= '0;
    end else if (out_en) begin
      valid_q  <= valid_d;
      spill_q  <= spill_d;
      target_q <= target_d;
    end
  end

  assign resp_valid  = valid_q;
  assign resp_spill  = spill_q;
  assign resp_target = target_q;

endmodule

// File: rtl/spill_picker_chk.sv
module spill_picker_chk #(
  parameter int unsigned ID_W   = 2,
  parameter int unsigned PROB_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PROB_W-1:0] coop_prob,
  input logic              req_valid,
  input logic [ID_W-1:0]   req_src,
  input logic              resp_valid,
  input logic              resp_spill,
  input logic [ID_W-1:0]   resp_target
);

  localparam logic [PROB_W-1:0] PMAX = '1;

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!resp_spill && resp_target == '0));

  a_r6_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && coop_prob == '0) |=> !resp_spill);

  a_r7_full_always: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && coop_prob == PMAX) |=> resp_spill);

  a_r9_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!resp_spill || resp_target != $past(req_src)));

  a_r10_nospill_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_spill) |-> resp_target == '0);

endmodule

bind spill_picker spill_picker_chk #(
  .ID_W  (ID_W),
  .PROB_W(PROB_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .coop_prob  (coop_prob),
  .req_valid  (req_valid),
  .req_src    (req_src),
  .resp_valid (resp_valid),
  .resp_spill (resp_spill),
  .resp_target(resp_target)
);

// File: tb/spill_picker_test.sv
`timescale 1ns/1ps
module spill_picker_test;

  logic        clk;
  logic        rst_n;
  logic        seed_load;
  logic [15:0] seed_value;
  logic [7:0]  coop_prob;
  logic        req_valid;
  logic [1:0]  req_src;
  logic        resp_valid;
  logic        resp_spill;
  logic [1:0]  resp_target;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  int hits [4];

  logic [15:0] model;

  spill_picker uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .coop_prob  (coop_prob),
    .req_valid  (req_valid),
    .req_src    (req_src),
    .resp_valid (resp_valid),
    .resp_spill (resp_spill),
    .resp_target(resp_target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference random state, built from the polynomial in R3 and R4.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model <= 16'hACE1;
    else if (seed_load) model <= (seed_value == 16'h0) ? 16'h0001 : seed_value;
    else model <= (model >> 1) ^ (model[0] ? 16'hB400 : 16'h0);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_spill(input logic [15:0] s, input logic [7:0] p);
    return (p == 8'd255) || (s[7:0] < p);
  endfunction

  function automatic logic [1:0] exp_target(input logic [15:0] s, input logic [1:0] src);
    int code = int'(s[10:8]);
    int off  = (code < 3) ? 1 : ((code < 6) ? 3 : 2);
    return 2'((int'(src) + off) % 4);
  endfunction

  // Drive at a negedge, check at the next negedge (one register stage).
  task automatic request(input logic [1:0] src, input logic [7:0] p, input bit load,
                         input logic [15:0] sv, input string tag);
    logic [15:0] s;
    bit          es;
    logic [1:0]  et;
    req_valid  = 1'b1;
    req_src    = src;
    coop_prob  = p;
    seed_load  = load;
    seed_value = sv;
    s  = model;
    es = exp_spill(s, p);
    et = es ? exp_target(s, src) : 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    seed_load = 1'b0;
    check(resp_valid == 1'b1, {tag, " R2 valid"}, int'(resp_valid), 1);
    check(resp_spill == es, {tag, " spill"}, int'(resp_spill), int'(es));
    check(resp_target == et, {tag, " target"}, int'(resp_target), int'(et));
    if (resp_spill) begin
      check(resp_target != src, "R9 not self", int'(resp_target), -1);
      hits[resp_target] = hits[resp_target] + 1;
    end
  endtask

  task automatic idle(input bit load, input logic [15:0] sv);
    seed_load  = load;
    seed_value = sv;
    @(negedge clk);
    seed_load = 1'b0;
    check(resp_valid == 1'b0 && resp_spill == 1'b0 && resp_target == 2'd0,
          "R1 R2 idle quiet", int'({resp_valid, resp_spill, resp_target}), 0);
  endtask

  initial begin
    logic [7:0] probs [7];
    probs = '{8'd0, 8'd1, 8'd37, 8'd128, 8'd200, 8'd254, 8'd255};
    rst_n = 1'b0; seed_load = 1'b0; seed_value = 16'h0;
    coop_prob = 8'd0; req_valid = 1'b0; req_src = 2'd0;
    #23;
    check(resp_valid == 1'b0 && resp_spill == 1'b0 && resp_target == 2'd0,
          "R1 reset", int'({resp_valid, resp_spill, resp_target}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: sequence from the reset value, always spilling.
    for (int i = 0; i < 16; i++) request(2'(i), 8'd255, 1'b0, 16'h0, "R3 R7 R8 reset seq");

    // R5 R6 R7 R8 R10: sweep thresholds and sources back to back.
    foreach (probs[k]) begin
      for (int src = 0; src < 4; src++) begin
        for (int n = 0; n < 12; n++) request(2'(src), probs[k], 1'b0, 16'h0, "R5 R6 R7 R8 R10 sweep");
      end
    end

    // R2 R3: the state keeps stepping through idle gaps.
    for (int i = 0; i < 20; i++) begin
      request(2'(i), 8'd128, 1'b0, 16'h0, "R2 R3 gapped");
      idle(1'b0, 16'h0);
      idle(1'b0, 16'h0);
    end

    // R4: explicit seed, then zero seed with a request in the same cycle.
    idle(1'b1, 16'h1234);
    for (int i = 0; i < 24; i++) request(2'(i), 8'd100, 1'b0, 16'h0, "R4 seeded");
    request(2'd2, 8'd255, 1'b1, 16'h0000, "R4 same-cycle load");
    check(model == 16'h0001, "R4 zero seed", int'(model), 1);
    for (int i = 0; i < 24; i++) request(2'(i), 8'd255, 1'b0, 16'h0, "R4 after zero seed");

    // R8 R9: long run from one source, all three hosts must appear.
    hits = '{0, 0, 0, 0};
    for (int i = 0; i < 400; i++) request(2'd1, 8'd255, 1'b0, 16'h0, "R8 R9 spread");
    check(hits[1] == 0, "R9 source never host", hits[1], 0);
    check(hits[2] > 0 && hits[0] > 0 && hits[3] > 0, "R8 all hosts seen",
          hits[0] * hits[2] * hits[3] > 0 ? 1 : 0, 1);
    check(hits[2] > hits[3] && hits[0] > hits[3], "R8 neighbours favoured",
          hits[3], (hits[0] < hits[2] ? hits[0] : hits[2]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule